// File: doc/BRIEF.md
# Deep-Stop Power Mode Sequencer

This block steers a small processor system into and out of a deep stop low-power mode. The processor asks for the mode by raising its sleep-deep indication together with a wait-for-interrupt or wait-for-event strobe. The sequencer honours the request only in full-run mode. It then holds off entry until any flash program operation and any peripheral-bus transfer have finished. While stopped, it freezes the pad states, holds the retention domains, keeps the non-retained logic in reset and turns the system clock off.

A wakeup interrupt or event ends the stop. The sequencer asks for the wakeup oscillator that a configuration bit chose at the moment of wakeup, and waits for that oscillator's ready signal. It then releases the non-retained reset and the pads and goes back to full run. A sticky status flag records that the stop took place and keeps that record until software clears it. The analog regulators and the oscillators are outside the block; they appear only as ready inputs and request outputs.

Top module: `dstop_seq`

## Requirements
- R1: After a synchronous reset, `mode_o` is 0 (run), all control outputs are low, `clk_sel_hsi` is 0 and `stop_flag` is 0. The mode codes are 0 run, 1 low-power run, 2 entry wait, 3 stopped and 4 wake clock.
- R2: In run mode, a cycle with both `sleep_deep` and `wait_instr` high moves the mode to 2 on the next edge. Either signal alone leaves the mode at 0.
- R3: `lprun_sel` high in run mode moves the mode to 1, and `lprun_sel` low there moves it back to 0. In mode 1 a deep-sleep request is ignored, the mode stays 1 and `pad_hold` stays low.
- R4: Mode 2 is left for mode 3 only on an edge where `flash_busy` and `bus_busy` are both low. Otherwise it stays in mode 2.
- R5: `wake_evt` high in mode 2 returns the mode to 0, takes priority over entry and leaves `stop_flag` unchanged.
- R6: In mode 3, `pad_hold`, `ret_hold`, `nonret_rst` and `clk_off` are all high and `osc_req` is low. Without `wake_evt` the mode stays 3.
- R7: `wake_evt` in mode 3 moves the mode to 4 and latches `wake_hsi_cfg` into `clk_sel_hsi` (1 selects the 16 MHz internal oscillator, 0 the multi-speed one). `clk_sel_hsi` then holds while the configuration bit changes.
- R8: In mode 4, `osc_req`, `pad_hold`, `ret_hold` and `nonret_rst` are high and `clk_off` is low. The block stays in mode 4 until the selected oscillator's ready input (`hsi_rdy` or `msi_rdy`) is high and ignores the other ready input. It then returns to mode 0 with all control outputs low.
- R9: `stop_flag` sets on the edge that leaves mode 3 through a wakeup and stays set until a `flag_clr` pulse. If the set and the clear fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_deep | input | 1 | Processor sleep-deep indication |
| wait_instr | input | 1 | Wait-for-interrupt or wait-for-event strobe |
| lprun_sel | input | 1 | Requests low-power run mode when high |
| flash_busy | input | 1 | Flash program operation in progress |
| bus_busy | input | 1 | Peripheral-bus access in progress |
| wake_evt | input | 1 | Wakeup interrupt or event |
| wake_hsi_cfg | input | 1 | Wakeup clock choice: 1 internal 16 MHz, 0 multi-speed |
| hsi_rdy | input | 1 | Internal 16 MHz oscillator ready |
| msi_rdy | input | 1 | Multi-speed oscillator ready |
| flag_clr | input | 1 | One-cycle clear pulse for the stop flag |
| mode_o | output | 3 | Current mode code |
| pad_hold | output | 1 | Freeze pad states |
| ret_hold | output | 1 | Hold retention domains |
| nonret_rst | output | 1 | Reset to non-retained logic |
| clk_off | output | 1 | System clock gated off |
| osc_req | output | 1 | Request for the selected wakeup oscillator |
| clk_sel_hsi | output | 1 | Selected wakeup clock, 1 internal 16 MHz |
| stop_flag | output | 1 | Sticky record of a completed stop |

## Verification
The properties assume that the busy, ready and wakeup inputs are synchronous single-bit levels that change only between clock edges. They also assume that `flag_clr` is a level sampled on each edge, not a strobe shorter than a cycle. The bench drives every input shortly after a rising edge and samples well before the next one. It holds each busy input low after its release within an entry attempt, and raises a ready input only while the sequencer waits in the wake clock mode, or the unselected one on purpose to show that it is ignored.

// File: rtl/dstop_pkg.sv
package dstop_pkg;

    typedef enum logic [2:0] {
        MD_RUN   = 3'd0,
        MD_LPRUN = 3'd1,
        MD_ENTRY = 3'd2,
        MD_STOP  = 3'd3,
        MD_WAKE  = 3'd4
    } dstop_mode_e;

    typedef struct packed {
        logic pad_hold;
        logic ret_hold;
        logic nonret_rst;
        logic clk_off;
        logic osc_req;
    } dstop_ctl_t;

    function automatic dstop_ctl_t ctl_of(input dstop_mode_e m);
        dstop_ctl_t c;
        c = '0;
        case (m)
            MD_STOP: begin
                c.pad_hold   = 1'b1;
                c.ret_hold   = 1'b1;
                c.nonret_rst = 1'b1;
                c.clk_off    = 1'b1;
            end
            MD_WAKE: begin
                c.pad_hold   = 1'b1;
                c.ret_hold   = 1'b1;
                c.nonret_rst = 1'b1;
                c.osc_req    = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/dstop_fsm.sv
module dstop_fsm
    import dstop_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        deep_req,
    input  logic        lprun_sel,
    input  logic        any_busy,
    input  logic        wake,
    input  logic        sel_rdy,
    output dstop_mode_e mode,
    output logic        stop_wake
);
    dstop_mode_e mode_nx;

    always_comb begin
        mode_nx = mode;
        case (mode)
            MD_RUN: begin
                if (deep_req)       mode_nx = MD_ENTRY;
                else if (lprun_sel) mode_nx = MD_LPRUN;
            end
            MD_LPRUN: if (!lprun_sel) mode_nx = MD_RUN;
            MD_ENTRY: begin
                if (wake)           mode_nx = MD_RUN;
                else if (!any_busy) mode_nx = MD_STOP;
            end
            MD_STOP:  if (wake)     mode_nx = MD_WAKE;
            MD_WAKE:  if (sel_rdy)  mode_nx = MD_RUN;
            default:                mode_nx = MD_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) mode <= MD_RUN;
        else     mode <= mode_nx;
    end

    assign stop_wake = (mode == MD_STOP) && wake;
endmodule

// File: rtl/dstop_wake_clk.sv
module dstop_wake_clk #(
    parameter bit SEL_RST = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic capture,
    input  logic cfg_hsi,
    input  logic hsi_rdy,
    input  logic msi_rdy,
    output logic sel_hsi,
    output logic sel_rdy
);
    always_ff @(posedge clk) begin
        if (rst)          sel_hsi <= SEL_RST;
        else if (capture) sel_hsi <= cfg_hsi;
    end

    assign sel_rdy = sel_hsi ? hsi_rdy : msi_rdy;
endmodule

// File: rtl/dstop_flag.sv
module dstop_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end
endmodule

// File: rtl/dstop_seq.sv
module dstop_seq
    import dstop_pkg::*;
#(
    parameter bit SEL_RST = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sleep_deep,
    input  logic       wait_instr,
    input  logic       lprun_sel,
    input  logic       flash_busy,
    input  logic       bus_busy,
    input  logic       wake_evt,
    input  logic       wake_hsi_cfg,
    input  logic       hsi_rdy,
    input  logic       msi_rdy,
    input  logic       flag_clr,
    output logic [2:0] mode_o,
    output logic       pad_hold,
    output logic       ret_hold,
    output logic       nonret_rst,
    output logic       clk_off,
    output logic       osc_req,
    output logic       clk_sel_hsi,
    output logic       stop_flag
);
    dstop_mode_e mode;
    dstop_ctl_t  ctl;
    logic        stop_wake;
    logic        sel_rdy;

    dstop_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .deep_req  (sleep_deep & wait_instr),
        .lprun_sel (lprun_sel),
        .any_busy  (flash_busy | bus_busy),
        .wake      (wake_evt),
        .sel_rdy   (sel_rdy),
        .mode      (mode),
        .stop_wake (stop_wake)
    );

    dstop_wake_clk #(.SEL_RST(SEL_RST)) u_wclk (
        .clk     (clk),
        .rst     (rst),
        .capture (stop_wake),
        .cfg_hsi (wake_hsi_cfg),
        .hsi_rdy (hsi_rdy),
        .msi_rdy (msi_rdy),
        .sel_hsi (clk_sel_hsi),
        .sel_rdy (sel_rdy)
    );

    dstop_flag u_flag (
        .clk  (clk),
        .rst  (rst),
        .set  (stop_wake),
        .clr  (flag_clr),
        .flag (stop_flag)
    );

    assign ctl        = ctl_of(mode);
    assign mode_o     = mode;
    assign pad_hold   = ctl.pad_hold;
    assign ret_hold   = ctl.ret_hold;
    assign nonret_rst = ctl.nonret_rst;
    assign clk_off    = ctl.clk_off;
    assign osc_req    = ctl.osc_req;
endmodule

// File: rtl/dstop_seq_chk.sv
module dstop_seq_chk
    import dstop_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       sleep_deep,
    input logic       wait_instr,
    input logic       lprun_sel,
    input logic       flash_busy,
    input logic       bus_busy,
    input logic       wake_evt,
    input logic       wake_hsi_cfg,
    input logic       hsi_rdy,
    input logic       msi_rdy,
    input logic       flag_clr,
    input logic [2:0] mode_o,
    input logic       pad_hold,
    input logic       ret_hold,
    input logic       nonret_rst,
    input logic       clk_off,
    input logic       osc_req,
    input logic       clk_sel_hsi,
    input logic       stop_flag
);
    a_r2_req_enters: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MD_RUN && sleep_deep && wait_instr) |=> (mode_o == MD_ENTRY));

    a_r3_lprun_stays: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MD_LPRUN && lprun_sel) |=> (mode_o == MD_LPRUN));

    a_r4_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MD_ENTRY && (flash_busy || bus_busy) && !wake_evt) |=> (mode_o == MD_ENTRY));

    a_r5_wake_cancels: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MD_ENTRY && wake_evt) |=> (mode_o == MD_RUN));

    a_r6_hold_after_entry: assert property (@(posedge clk) disable iff (rst)
        $rose(pad_hold) |-> ($past(mode_o) == MD_ENTRY));

    a_r6_clk_off_with_reset: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_off) |-> (ret_hold && nonret_rst));

    a_r7_sel_captured: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MD_STOP && wake_evt) |=> (clk_sel_hsi == $past(wake_hsi_cfg) && osc_req));

    a_r8_waits_ready: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MD_WAKE && !(clk_sel_hsi ? hsi_rdy : msi_rdy)) |=> (mode_o == MD_WAKE));

    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MD_STOP && wake_evt) |=> stop_flag);

    a_r9_clear_works: assert property (@(posedge clk) disable iff (rst)
        (!(mode_o == MD_STOP && wake_evt) && flag_clr) |=> !stop_flag);
endmodule

bind dstop_seq dstop_seq_chk i_chk (.*);

// File: tb/test_dstop_seq.sv
module test_dstop_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sleep_deep = 0, wait_instr = 0, lprun_sel = 0;
    logic       flash_busy = 0, bus_busy = 0, wake_evt = 0, wake_hsi_cfg = 0;
    logic       hsi_rdy = 0, msi_rdy = 0, flag_clr = 0;
    logic [2:0] mode_o;
    logic       pad_hold, ret_hold, nonret_rst, clk_off, osc_req, clk_sel_hsi, stop_flag;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    dstop_seq i_dstop_seq (
        .clk(clk), .rst(rst), .sleep_deep(sleep_deep), .wait_instr(wait_instr),
        .lprun_sel(lprun_sel), .flash_busy(flash_busy), .bus_busy(bus_busy),
        .wake_evt(wake_evt), .wake_hsi_cfg(wake_hsi_cfg), .hsi_rdy(hsi_rdy),
        .msi_rdy(msi_rdy), .flag_clr(flag_clr), .mode_o(mode_o),
        .pad_hold(pad_hold), .ret_hold(ret_hold), .nonret_rst(nonret_rst),
        .clk_off(clk_off), .osc_req(osc_req), .clk_sel_hsi(clk_sel_hsi),
        .stop_flag(stop_flag)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    initial begin
        for (int n = 0; n < 100000 && !done; n++) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(); step(); step();
        // R1 reset state
        chk("R1", "mode", mode_o, 0);
        chk("R1", "ctl", {pad_hold, ret_hold, nonret_rst, clk_off, osc_req}, 0);
        chk("R1", "sel", clk_sel_hsi, 0);
        chk("R1", "flag", stop_flag, 0);
        rst = 0;
        step();
        chk("R1", "mode after release", mode_o, 0);

        // R2 partial requests do nothing
        wait_instr = 1; step();
        chk("R2", "wait only", mode_o, 0);
        wait_instr = 0; sleep_deep = 1; step();
        chk("R2", "sleep only", mode_o, 0);
        sleep_deep = 0;

        // R3 low-power run ignores the request
        lprun_sel = 1; step();
        chk("R3", "enter lprun", mode_o, 1);
        sleep_deep = 1; wait_instr = 1;
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R3", "req ignored", mode_o, 1);
            chk("R3", "pads free", pad_hold, 0);
        end
        sleep_deep = 0; wait_instr = 0; lprun_sel = 0; step();
        chk("R3", "back to run", mode_o, 0);

        // R4/R6/R7/R8/R9 sweep over busy release and ready delays
        for (int fd = 0; fd < 4; fd++) begin
            for (int bd = 0; bd < 4; bd++) begin
                int m;
                int d;
                bit cfg;
                m   = (fd > bd) ? fd : bd;
                if (m < 1) m = 1;
                d   = fd;
                cfg = 1'((fd + bd) & 1);
                for (int c = 0; c <= m; c++) begin
                    sleep_deep = (c == 0); wait_instr = (c == 0);
                    flash_busy = (c < fd); bus_busy = (c < bd);
                    step();
                    chk("R4", "entry mode", mode_o, (c < m) ? 2 : 3);
                    chk("R6", "pad hold", pad_hold, (c < m) ? 0 : 1);
                end
                sleep_deep = 0; wait_instr = 0; flash_busy = 0; bus_busy = 0;
                step();
                chk("R6", "stays stopped", mode_o, 3);
                chk("R6", "stop ctl", {pad_hold, ret_hold, nonret_rst, clk_off, osc_req}, 5'b11110);
                wake_evt = 1; wake_hsi_cfg = cfg; hsi_rdy = 0; msi_rdy = 0;
                step();
                chk("R7", "wake mode", mode_o, 4);
                chk("R7", "sel latched", clk_sel_hsi, cfg);
                chk("R8", "wake ctl", {pad_hold, ret_hold, nonret_rst, clk_off, osc_req}, 5'b11101);
                chk("R9", "flag set", stop_flag, 1);
                for (int j = 1; j < 8; j++) begin
                    int ex;
                    wake_evt = 0; wake_hsi_cfg = ~cfg;
                    if (cfg) begin hsi_rdy = (j >= d); msi_rdy = 1; end
                    else     begin msi_rdy = (j >= d); hsi_rdy = 1; end
                    step();
                    ex = (j < ((d < 1) ? 1 : d)) ? 4 : 0;
                    chk("R8", "ready wait", mode_o, ex);
                    chk("R7", "sel held", clk_sel_hsi, cfg);
                    if (ex == 0) begin
                        chk("R8", "released", {pad_hold, ret_hold, nonret_rst, clk_off, osc_req}, 0);
                        break;
                    end
                end
                hsi_rdy = 0; msi_rdy = 0;
                step();
                chk("R9", "flag sticky", stop_flag, 1);
                flag_clr = 1; step(); flag_clr = 0;
                chk("R9", "flag cleared", stop_flag, 0);
            end
        end

        // R5 wakeup during entry wait cancels
        sleep_deep = 1; wait_instr = 1; flash_busy = 1; step();
        sleep_deep = 0; wait_instr = 0;
        chk("R5", "in entry", mode_o, 2);
        wake_evt = 1; step();
        wake_evt = 0; flash_busy = 0;
        chk("R5", "cancelled", mode_o, 0);
        chk("R5", "flag untouched", stop_flag, 0);
        chk("R5", "pads free", pad_hold, 0);
        step();
        chk("R5", "stays run", mode_o, 0);

        // R9 set and clear in the same cycle
        sleep_deep = 1; wait_instr = 1; step();
        sleep_deep = 0; wait_instr = 0; step();
        chk("R9", "stopped", mode_o, 3);
        wake_evt = 1; flag_clr = 1; wake_hsi_cfg = 0; step();
        wake_evt = 0; flag_clr = 0;
        chk("R9", "set wins", stop_flag, 1);
        msi_rdy = 1; step();
        chk("R8", "msi ready", mode_o, 0);
        msi_rdy = 0;
        step(); step();
        chk("R9", "still set", stop_flag, 1);
        flag_clr = 1; step(); flag_clr = 0;
        chk("R9", "clear", stop_flag, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule